// File: doc/BRIEF.md
# Four-Channel Register-Started Block Copy Engine

This block copies blocks of memory on behalf of software. It has four channels. Each channel has a control word, an element count, and 64-bit source, destination and chain addresses. Software programs these through a word-wide register write port and reads them back through a combinational read port. A write to a channel's control word with the enable bit set starts that channel's copy. The copy runs one element at a time. An element is 1, 2, 4 or 8 bytes wide. Each element is first read from the source address and then written to the destination address, over a request/acknowledge memory master port.

All channels share one mover, so transfers run one after another. When the mover is free, it serves the lowest-numbered channel that has a copy waiting. A per-channel busy flag is set from the start write until the last element has been written. While the flag is set, that channel's registers are locked against writes. The chain address and two spare words (sleep, polarity) are plain storage. The status and chain-command slots read as zero.

Top module: `blkdma_top`

## Requirements
- R1: After reset, every register slot reads zero, `busy` is all zeros and `mem_req` is low.
- R2: Register address = channel*8 + slot for channels 0..3. Slots 0..7 are: control, count, source-high, source-low, destination-high, destination-low, chain-high, chain-low. A write to a high half replaces bits 63:32 and leaves bits 31:0 intact. A write to a low half does the reverse.
- R3: A write to a control slot with bit 31 set, to a channel whose busy flag is clear, sets that channel's `busy` bit at the next clock edge.
- R4: Control bits 26:25 are a size code c. The element is 2^c bytes and `mem_size` carries c. Data is little-endian in the low lanes of the 64-bit buses: byte k of the element sits at address+k and in lane k. Write data holds exactly the bytes read for that element, and lanes above the element are zero.
- R5: Control bit 23 enables source increment and bit 24 enables destination increment. When the bit is set, that address advances by the element size after each element. When it is clear, every element uses the same address.
- R6: The element count is bits 15:0 of the count register; bits 31:16 are ignored. A count of zero ends the copy with no memory access, and `busy` clears again.
- R7: For each element, a read is issued and then a write. `mem_req` stays high, with address, direction and size stable, until `mem_ack` is seen at a clock edge.
- R8: While a channel is busy, every write to its eight slots is ignored, including a second start.
- R9: Only one copy runs at a time. When the mover is free, it takes the lowest-numbered busy channel. Memory requests appear only while some channel is busy.
- R10: Slot 32 (status) and slot 33 (chain command) read zero and ignore writes. Slot 34 (sleep) and slot 35 (polarity) store and return the written word.
- R11: Control bit 2 (decrement) has no effect on the order or addresses of the memory accesses.
- R12: A copy does not change any channel register; after completion the programmed values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Register slot address, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| busy | output | NCH (4) | Per-channel busy flags |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Element size code (bytes = 2^code) |
| mem_addr | output | 64 | Byte address of the element |
| mem_wdata | output | 64 | Write data, element in the low lanes |
| mem_ack | input | 1 | Acknowledge; completes the request at this edge |
| mem_rdata | input | 64 | Read data, valid together with `mem_ack` on a read |

## Verification
The bench drives the memory side with lanes above the element filled with junk. A mover that skipped masking would then write wrong upper lanes. Copies with one address held show whether the increment enables are wired the right way round. With the source held, the destination gets the same byte repeated. With the destination held, only the last element remains. A count register with its upper half set, and a count of zero, expose a wrong count width or a zero count that wraps into a 65536-element copy. Three channels queued behind a long copy check the pick order, and writes aimed at the running channel check the busy lock. A broken pick order interleaves the wrong channel's accesses, and a missing lock restarts or redirects the copy.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    localparam int REG_W  = 32;
    localparam int MA_W   = 64;
    localparam int MD_W   = 64;
    localparam int SLOT_W = 3;
    localparam int CNT_W  = 16;

    // control word bit positions
    localparam int CTL_EN   = 31;
    localparam int CTL_WID  = 25;
    localparam int CTL_DINC = 24;
    localparam int CTL_SINC = 23;
    localparam int CTL_DEC  = 2;

    localparam logic [SLOT_W-1:0] SL_CTRL = 3'd0;
    localparam logic [SLOT_W-1:0] SL_CNT  = 3'd1;
    localparam logic [SLOT_W-1:0] SL_SRCH = 3'd2;
    localparam logic [SLOT_W-1:0] SL_SRCL = 3'd3;
    localparam logic [SLOT_W-1:0] SL_DSTH = 3'd4;
    localparam logic [SLOT_W-1:0] SL_DSTL = 3'd5;
    localparam logic [SLOT_W-1:0] SL_SGH  = 3'd6;
    localparam logic [SLOT_W-1:0] SL_SGL  = 3'd7;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] cnt;
        logic [MA_W-1:0]  src;
        logic [MA_W-1:0]  dst;
        logic [MA_W-1:0]  sg;
    } chregs_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_RD   = 2'd1,
        ENG_WR   = 2'd2
    } eng_e;

    function automatic logic [MD_W-1:0] lane_mask(input logic [1:0] code);
        logic [MD_W-1:0] m;
        case (code)
            2'd0:    m = MD_W'(64'h0000_0000_0000_00FF);
            2'd1:    m = MD_W'(64'h0000_0000_0000_FFFF);
            2'd2:    m = MD_W'(64'h0000_0000_FFFF_FFFF);
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [MA_W-1:0] elem_bytes(input logic [1:0] code);
        return MA_W'(1) << code;
    endfunction

endpackage

// File: rtl/blkdma_chregs.sv
module blkdma_chregs
    import blkdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] slot,
    input  logic [REG_W-1:0]  wdata,
    output chregs_t           regs
);

    chregs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (slot)
                SL_CTRL: regs_d.ctrl             = wdata;
                SL_CNT:  regs_d.cnt              = wdata;
                SL_SRCH: regs_d.src[MA_W-1:REG_W] = wdata;
                SL_SRCL: regs_d.src[REG_W-1:0]    = wdata;
                SL_DSTH: regs_d.dst[MA_W-1:REG_W] = wdata;
                SL_DSTL: regs_d.dst[REG_W-1:0]    = wdata;
                SL_SGH:  regs_d.sg[MA_W-1:REG_W]  = wdata;
                default: regs_d.sg[REG_W-1:0]     = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

endmodule

// File: rtl/blkdma_mover.sv
module blkdma_mover
    import blkdma_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      start,
    input  chregs_t [NCH-1:0]   regs,
    output logic [NCH-1:0]      busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [1:0]          mem_size,
    output logic [MA_W-1:0]     mem_addr,
    output logic [MD_W-1:0]     mem_wdata,
    input  logic                mem_ack,
    input  logic [MD_W-1:0]     mem_rdata
);

    typedef struct packed {
        eng_e             st;
        logic [CH_W-1:0]  ch;
        logic [MA_W-1:0]  src;
        logic [MA_W-1:0]  dst;
        logic [CNT_W-1:0] left;
        logic [1:0]       wid;
        logic             sinc;
        logic             dinc;
        logic [MD_W-1:0]  hold;
        logic [NCH-1:0]   busy;
    } eng_t;

    eng_t eng_d, eng_q;

    logic            found;
    logic [CH_W-1:0] pick;
    chregs_t         sel;

    // fixed priority: lowest-numbered waiting channel wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (eng_q.busy[c]) begin
                found = 1'b1;
                pick  = CH_W'(c);
            end
        end
    end

    assign sel = regs[pick];

    always_comb begin
        eng_d      = eng_q;
        eng_d.busy = eng_q.busy | start;
        case (eng_q.st)
            ENG_IDLE: begin
                if (found) begin
                    eng_d.ch   = pick;
                    eng_d.src  = sel.src;
                    eng_d.dst  = sel.dst;
                    eng_d.left = sel.cnt[CNT_W-1:0];
                    eng_d.wid  = sel.ctrl[CTL_WID +: 2];
                    eng_d.sinc = sel.ctrl[CTL_SINC];
                    eng_d.dinc = sel.ctrl[CTL_DINC];
                    if (sel.cnt[CNT_W-1:0] == '0) eng_d.busy[pick] = 1'b0;
                    else                          eng_d.st         = ENG_RD;
                end
            end
            ENG_RD: begin
                if (mem_ack) begin
                    eng_d.hold = mem_rdata & lane_mask(eng_q.wid);
                    eng_d.st   = ENG_WR;
                end
            end
            ENG_WR: begin
                if (mem_ack) begin
                    eng_d.left = eng_q.left - CNT_W'(1);
                    if (eng_q.sinc) eng_d.src = eng_q.src + elem_bytes(eng_q.wid);
                    if (eng_q.dinc) eng_d.dst = eng_q.dst + elem_bytes(eng_q.wid);
                    if (eng_q.left == CNT_W'(1)) begin
                        eng_d.busy[eng_q.ch] = 1'b0;
                        eng_d.st             = ENG_IDLE;
                    end else begin
                        eng_d.st = ENG_RD;
                    end
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign busy      = eng_q.busy;
    assign mem_req   = (eng_q.st != ENG_IDLE);
    assign mem_we    = (eng_q.st == ENG_WR);
    assign mem_size  = eng_q.wid;
    assign mem_addr  = (eng_q.st == ENG_WR) ? eng_q.dst : eng_q.src;
    assign mem_wdata = eng_q.hold;

    // chain address, decrement flag and upper count bits are storage only
    logic unused_fields;
    assign unused_fields = ^regs;

endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
    import blkdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = $clog2(NCH * 8 + 4)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [NCH-1:0]   busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [1:0]       mem_size,
    output logic [MA_W-1:0]  mem_addr,
    output logic [MD_W-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [MD_W-1:0]  mem_rdata
);

    localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CHAN_SLOTS = NCH * 8;
    localparam int A_STAT     = CHAN_SLOTS;
    localparam int A_SGCMD    = CHAN_SLOTS + 1;
    localparam int A_SLEEP    = CHAN_SLOTS + 2;
    localparam int A_POL      = CHAN_SLOTS + 3;

    typedef struct packed {
        logic [REG_W-1:0] sleep;
        logic [REG_W-1:0] pol;
    } aux_t;

    aux_t aux_d, aux_q;

    logic              is_chan;
    logic [CH_W-1:0]   ch_sel;
    logic [SLOT_W-1:0] slot;
    logic [NCH-1:0]    wr_en;
    logic [NCH-1:0]    start;
    chregs_t [NCH-1:0] regs;

    assign is_chan = (reg_addr < AW'(CHAN_SLOTS));
    assign ch_sel  = reg_addr[SLOT_W +: CH_W];
    assign slot    = reg_addr[SLOT_W-1:0];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            assign wr_en[c] = reg_wr && is_chan && (ch_sel == CH_W'(c)) && !busy[c];
            assign start[c] = wr_en[c] && (slot == SL_CTRL) && reg_wdata[CTL_EN];

            blkdma_chregs u_regs (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (wr_en[c]),
                .slot  (slot),
                .wdata (reg_wdata),
                .regs  (regs[c])
            );
        end
    endgenerate

    blkdma_mover #(.NCH(NCH)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .regs      (regs),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_size  (mem_size),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    // spare words: sleep and polarity are storage, status and chain command are not
    always_comb begin
        aux_d = aux_q;
        if (reg_wr && reg_addr == AW'(A_SLEEP)) aux_d.sleep = reg_wdata;
        if (reg_wr && reg_addr == AW'(A_POL))   aux_d.pol   = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) aux_q <= '0;
        else        aux_q <= aux_d;
    end

    chregs_t rsel;
    assign rsel = regs[ch_sel];

    always_comb begin
        reg_rdata = '0;
        if (is_chan) begin
            case (slot)
                SL_CTRL: reg_rdata = rsel.ctrl;
                SL_CNT:  reg_rdata = rsel.cnt;
                SL_SRCH: reg_rdata = rsel.src[MA_W-1:REG_W];
                SL_SRCL: reg_rdata = rsel.src[REG_W-1:0];
                SL_DSTH: reg_rdata = rsel.dst[MA_W-1:REG_W];
                SL_DSTL: reg_rdata = rsel.dst[REG_W-1:0];
                SL_SGH:  reg_rdata = rsel.sg[MA_W-1:REG_W];
                default: reg_rdata = rsel.sg[REG_W-1:0];
            endcase
        end else if (reg_addr == AW'(A_SLEEP)) begin
            reg_rdata = aux_q.sleep;
        end else if (reg_addr == AW'(A_POL)) begin
            reg_rdata = aux_q.pol;
        end else if (reg_addr == AW'(A_STAT) || reg_addr == AW'(A_SGCMD)) begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk
    import blkdma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [AW-1:0]    reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic [NCH-1:0]   busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic [1:0]       mem_size,
    input logic [MA_W-1:0]  mem_addr,
    input logic [MD_W-1:0]  mem_wdata,
    input logic             mem_ack
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size)));

    p_wlanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_wdata & ~lane_mask(mem_size)) == '0));

    p_req_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy != '0));

    p_spare_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(NCH * 8) || reg_addr == AW'(NCH * 8 + 1)) |-> (reg_rdata == '0));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_start
            p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_wr && reg_addr < AW'(NCH * 8) && reg_addr[SLOT_W +: CH_W] == CH_W'(c)
                 && reg_addr[SLOT_W-1:0] == SL_CTRL && reg_wdata[CTL_EN] && !busy[c])
                |=> busy[c]);
        end
    endgenerate

    logic unused_chk;
    assign unused_chk = ^reg_wdata;

endmodule

bind blkdma_top blkdma_chk #(.NCH(NCH), .AW(AW)) u_blkdma_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_size  (mem_size),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/blkdma_top_bench.sv
module blkdma_top_bench;

    localparam int NCH = 4;
    localparam int AW  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [NCH-1:0]    busy;
    logic              mem_req, mem_we;
    logic [1:0]        mem_size;
    logic [63:0]       mem_addr, mem_wdata;
    logic              mem_ack = 1'b0;
    logic [63:0]       mem_rdata = '0;

    blkdma_top #(.NCH(NCH)) u_blkdma_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    typedef struct {
        bit              we;
        longint unsigned addr;
        logic [1:0]      size;
    } xact_t;

    xact_t           chq [NCH][$];
    int              cur = -1;
    logic [63:0]     last_rd = '0;
    int              hs_cnt = 0;
    logic [7:0]      mem [longint unsigned];

    function automatic void chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic logic [7:0] rd_byte(longint unsigned a);
        if (mem.exists(a)) return mem[a];
        return 8'(a ^ 64'h5A);
    endfunction

    function automatic logic [63:0] bmask(logic [1:0] code);
        return (code == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * (1 << code))) - 64'd1);
    endfunction

    function automatic logic [31:0] cw(logic [1:0] w, bit dinc, bit sinc, bit dec);
        return (32'd1 << 31) | (32'(w) << 25) | (32'(dinc) << 24) | (32'(sinc) << 23) | (32'(dec) << 2);
    endfunction

    // memory responder and cycle-by-cycle reference of the access stream
    bit              waiting = 0;
    int              wcnt = 0;
    longint unsigned w_addr;
    bit              w_we;

    always @(negedge clk) begin
        mem_ack = 1'b0;
        if (rst_n && mem_req) begin
            if (!waiting) begin
                waiting = 1; w_addr = mem_addr; w_we = mem_we; wcnt = 0;
            end else if (mem_addr != w_addr || mem_we != w_we) begin
                chk("R7 request changed before ack", {mem_addr[62:0], mem_we}, {w_addr[62:0], w_we});
            end
            if (wcnt >= (hs_cnt % 3)) begin
                mem_ack = 1'b1;
                waiting = 0;
                hs_cnt++;
                if (cur < 0 || chq[cur].size() == 0) begin
                    cur = -1;
                    for (int c = NCH - 1; c >= 0; c--) if (chq[c].size() != 0) cur = c;
                end
                if (cur < 0) begin
                    chk("R9 unexpected memory access", 64'd1, 64'd0);
                end else begin
                    xact_t e;
                    e = chq[cur].pop_front();
                    chk("R7 access direction", 64'(mem_we), 64'(e.we));
                    chk("R5 access address", mem_addr, e.addr);
                    chk("R4 size code", 64'(mem_size), 64'(e.size));
                    if (!mem_we) begin
                        logic [63:0] dat;
                        dat = '0;
                        for (int i = 0; i < (1 << e.size); i++) dat[8*i +: 8] = rd_byte(e.addr + longint'(i));
                        last_rd   = dat;
                        mem_rdata = dat | (~bmask(e.size) & 64'hC3A5_96F0_0F69_5A3C);
                    end else begin
                        chk("R4 write data lanes", mem_wdata, last_rd);
                        for (int i = 0; i < (1 << e.size); i++) mem[e.addr + longint'(i)] = mem_wdata[8*i +: 8];
                    end
                end
            end else begin
                wcnt++;
            end
        end else begin
            waiting = 0;
        end
    end

    task automatic wr(int a, logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 v = reg_rdata;
    endtask

    task automatic start_ch(int c, logic [31:0] ctrl, logic [31:0] cnt,
                            longint unsigned src, longint unsigned dst);
        longint unsigned s = src;
        longint unsigned d = dst;
        logic [1:0] w = ctrl[26:25];
        for (int i = 0; i < int'(cnt[15:0]); i++) begin
            chq[c].push_back('{we: 1'b0, addr: s, size: w});
            chq[c].push_back('{we: 1'b1, addr: d, size: w});
            if (ctrl[23]) s += longint'(1) << w;
            if (ctrl[24]) d += longint'(1) << w;
        end
        wr(c*8 + 1, cnt);
        wr(c*8 + 2, src[63:32]);
        wr(c*8 + 3, src[31:0]);
        wr(c*8 + 4, dst[63:32]);
        wr(c*8 + 5, dst[31:0]);
        wr(c*8 + 0, ctrl);
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy != '0 && n < 5000);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int hs0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 busy after reset", 64'(busy), 64'd0);
        chk("R1 mem_req after reset", 64'(mem_req), 64'd0);
        for (int a = 0; a < NCH*8 + 4; a++) begin
            rd(a, v);
            chk("R1 slot zero after reset", 64'(v), 64'd0);
        end

        // R2 halves are independent
        wr(0*8 + 5, 32'h1111_2222);
        wr(0*8 + 4, 32'h3333_4444);
        wr(0*8 + 5, 32'h5555_6666);
        rd(0*8 + 4, v); chk("R2 dest high kept", 64'(v), 64'h3333_4444);
        rd(0*8 + 5, v); chk("R2 dest low replaced", 64'(v), 64'h5555_6666);
        wr(2*8 + 6, 32'hABCD_0001);
        wr(2*8 + 7, 32'h0000_FEED);
        rd(2*8 + 6, v); chk("R2 chain high", 64'(v), 64'hABCD_0001);
        rd(2*8 + 7, v); chk("R2 chain low", 64'(v), 64'h0000_FEED);

        // R3 R4 R5: 4-byte elements, both addresses advance
        start_ch(0, cw(2'd2, 1, 1, 0), 32'd3, 64'h1000, 64'h2000);
        chk("R3 busy set after start", 64'(busy[0]), 64'd1);
        wait_idle();
        for (int i = 0; i < 12; i++)
            chk("R4 copied byte", 64'(rd_byte(64'h2000 + longint'(i))), 64'(rd_byte(64'h1000 + longint'(i))));
        chk("R5 all accesses seen ch0", 64'(chq[0].size()), 64'd0);

        // R5 R11: byte elements, source held, decrement flag set
        start_ch(1, cw(2'd0, 1, 0, 1), 32'd4, 64'h3000, 64'h4000);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk("R5 held source repeated", 64'(rd_byte(64'h4000 + longint'(i))), 64'(rd_byte(64'h3000)));
        chk("R11 byte past end untouched", 64'(rd_byte(64'h4004)), 64'(8'(64'h4004 ^ 64'h5A)));

        // R5: 8-byte elements, destination held
        start_ch(2, cw(2'd3, 0, 1, 0), 32'd2, 64'h5000, 64'h6000);
        wait_idle();
        for (int i = 0; i < 8; i++)
            chk("R5 held dest keeps last", 64'(rd_byte(64'h6000 + longint'(i))), 64'(rd_byte(64'h5008 + longint'(i))));

        // R6: upper count bits ignored
        start_ch(3, cw(2'd1, 1, 1, 0), 32'h0005_0003, 64'h7000, 64'h8000);
        wait_idle();
        for (int i = 0; i < 6; i++)
            chk("R6 copied halfword byte", 64'(rd_byte(64'h8000 + longint'(i))), 64'(rd_byte(64'h7000 + longint'(i))));
        chk("R6 stop after low count", 64'(rd_byte(64'h8006)), 64'(8'(64'h8006 ^ 64'h5A)));

        // R6: zero count
        hs0 = hs_cnt;
        start_ch(0, cw(2'd2, 1, 1, 0), 32'hFFFF_0000, 64'h1000, 64'h2000);
        wait_idle();
        chk("R6 zero count no access", 64'(hs_cnt), 64'(hs0));
        chk("R6 zero count busy clear", 64'(busy), 64'd0);

        // R2: full 64-bit addresses
        start_ch(1, cw(2'd2, 1, 1, 0), 32'd1, 64'h1_0000_0100, 64'h2_0000_0200);
        wait_idle();
        for (int i = 0; i < 4; i++)
            chk("R2 64-bit copy", 64'(rd_byte(64'h2_0000_0200 + longint'(i))), 64'(rd_byte(64'h1_0000_0100 + longint'(i))));

        // R8 R9 R12: lock while busy, priority among waiting channels
        start_ch(3, cw(2'd0, 1, 1, 0), 32'd20, 64'h9000, 64'hA000);
        wr(3*8 + 3, 32'h0000_FFFF);
        wr(3*8 + 0, cw(2'd0, 1, 1, 0));
        start_ch(2, cw(2'd0, 1, 1, 0), 32'd2, 64'hB000, 64'hC000);
        start_ch(1, cw(2'd0, 1, 1, 0), 32'd2, 64'hD000, 64'hE000);
        wait_idle();
        for (int c = 0; c < NCH; c++)
            chk("R9 every queued access done", 64'(chq[c].size()), 64'd0);
        rd(3*8 + 3, v); chk("R8 locked source low", 64'(v), 64'h9000);
        rd(3*8 + 1, v); chk("R12 count kept", 64'(v), 64'd20);
        rd(3*8 + 0, v); chk("R12 control kept", 64'(v), 64'(cw(2'd0, 1, 1, 0)));
        rd(3*8 + 5, v); chk("R12 dest low kept", 64'(v), 64'hA000);

        // R10 spare slots
        wr(NCH*8 + 0, 32'hFFFF_FFFF);
        wr(NCH*8 + 1, 32'hFFFF_FFFF);
        wr(NCH*8 + 2, 32'h1234_5678);
        wr(NCH*8 + 3, 32'h0000_A5A5);
        rd(NCH*8 + 0, v); chk("R10 status reads zero", 64'(v), 64'd0);
        rd(NCH*8 + 1, v); chk("R10 chain command reads zero", 64'(v), 64'd0);
        rd(NCH*8 + 2, v); chk("R10 sleep stored", 64'(v), 64'h1234_5678);
        rd(NCH*8 + 3, v); chk("R10 polarity stored", 64'(v), 64'hA5A5);
        chk("R9 no request when idle", 64'(mem_req), 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end

endmodule